// File: doc/BRIEF.md
# ARINC 429 Word Transmitter with Queue

This block takes 32-bit avionics serial words from a 16-bit host bus and sends them out bit by bit. The host writes each word as two halves: one strobe captures the low half, and a later strobe captures the high half. The second strobe completes the word and places it in an eight-entry queue. The block then takes words from the queue in order while the transmit enable input is high.

Bit 32 of each word carries either the host's own bit or a parity bit that the block generates. The parity sense is selectable. Each bit lasts ten ticks of a divided clock, so a bit takes 10 or 80 master clocks depending on the rate select. The bit is sent as a return-to-zero pulse on one of two lines: one line for ones and the other for zeros.

A ready flag tells the host when the queue has drained and the line has gone quiet. A full flag shows that the queue has no room left.

Top module: `arinc_tx`

## Requirements
- R1: Words are transmitted in the order they were completed, and the queue holds up to 8 complete words.
- R2: A `wr_lo` strobe captures the low half. A later `wr_hi` strobe captures the high half and queues the word. A `wr_lo` with no `wr_hi` after it queues nothing. A `wr_hi` with no `wr_lo` before it is ignored.
- R3: `fifo_full` is high while 8 words are queued. A completing `wr_hi` while the queue is full is ignored, and that word is never transmitted.
- R4: `tx_ready` is high after reset. It drops in the cycle after a word is queued. It stays low while any bit is being sent. It rises once the 32nd bit's period has ended and the queue is empty.
- R5: With `par_en` = 0, transmitted bit 32 equals host bit 15 of the high half.
- R6: With `par_en` = 1, bit 32 is generated from transmitted bits 1..31. With `par_even` = 0 the 32-bit word has an odd number of ones. With `par_even` = 1 it has an even number.
- R7: Bits leave in the order bit 1 first through bit 32 last. Bit n is bit n-1 of the word `{high half, low half}`.
- R8: Each bit lasts 10 master clocks with `rate_slow` = 0 and 80 master clocks with `rate_slow` = 1. The active line is high for the first half of the bit (5 or 40 clocks) and low for the rest.
- R9: `line_one` pulses only for 1 bits and `line_zero` pulses only for 0 bits. The two lines are never high together.
- R10: Between consecutive words both lines stay low for at least 4 bit periods. As a result, the first rise of a word comes at least 5 bit periods after the last rise of the previous word.
- R11: A word starts only while `tx_en` is high. With `tx_en` low, queued words wait and both lines stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 16 | Host data half-word |
| wr_lo | input | 1 | Strobe that captures the low half |
| wr_hi | input | 1 | Strobe that captures the high half and queues the word |
| rate_slow | input | 1 | 1 selects 80 clocks per bit, 0 selects 10 |
| par_en | input | 1 | 1 puts generated parity in bit 32 |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| tx_en | input | 1 | Allows a new word to start |
| line_one | output | 1 | Return-to-zero pulse for each 1 bit |
| line_zero | output | 1 | Return-to-zero pulse for each 0 bit |
| tx_ready | output | 1 | Queue empty and no bit in progress |
| fifo_full | output | 1 | Queue holds 8 words |

## Verification
The assertions assume that `wr_lo` and `wr_hi` never pulse in the same cycle. They also assume that `rate_slow`, `par_en` and `par_even` stay steady while a word is on the line. The bench raises each strobe for exactly one cycle, never both together. It changes the configuration inputs only while `tx_ready` is high or while `tx_en` holds transmission back. Under those limits, the checker's claims about line exclusivity, ready timing, the full limit and gated starts cover every cycle after reset.

// File: rtl/arinc_tx.sv
module arinc_tx #(
  parameter int DEPTH         = 8,
  parameter int HALF_W        = 16,
  parameter int TICKS_PER_BIT = 10,
  parameter int HIGH_TICKS    = 5,
  parameter int GAP_BITS      = 4,
  parameter int SLOW_PRE      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] din,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              rate_slow,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              tx_en,
  output logic              line_one,
  output logic              line_zero,
  output logic              tx_ready,
  output logic              fifo_full
);
  localparam int WORD_W    = 2 * HALF_W;
  localparam int AW        = $clog2(DEPTH);
  localparam int CW        = $clog2(DEPTH + 1);
  localparam int BW        = $clog2(WORD_W);
  localparam int PW        = $clog2(TICKS_PER_BIT);
  localparam int GAP_TICKS = GAP_BITS * TICKS_PER_BIT;
  localparam int GW        = $clog2(GAP_TICKS);
  localparam int SW        = $clog2(SLOW_PRE);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP} state_t;

  state_t            state;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     count;
  logic [HALF_W-1:0] lo_half;
  logic              lo_valid;
  logic [WORD_W-1:0] sh;
  logic [BW-1:0]     bitn;
  logic [PW-1:0]     phase;
  logic [GW-1:0]     gcnt;
  logic [SW-1:0]     pre;
  logic [WORD_W-1:0] head;
  logic              push, start, tick, sending, bit_end, b32, pulse_on;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head      = mem[rptr];
  assign b32       = par_en ? ((^head[WORD_W-2:0]) ^ ~par_even) : head[WORD_W-1];
  assign push      = wr_hi & lo_valid & ~fifo_full;
  assign start     = (state == S_IDLE) & (count != '0) & tx_en;
  assign tick      = rate_slow ? (pre == SW'(SLOW_PRE - 1)) : 1'b1;
  assign bit_end   = tick & (phase == PW'(TICKS_PER_BIT - 1));
  assign sending   = (state == S_SEND);
  assign pulse_on  = sending & (phase < PW'(HIGH_TICKS));
  assign line_one  = pulse_on & sh[0];
  assign line_zero = pulse_on & ~sh[0];
  assign tx_ready  = (count == '0) & ~sending;
  assign fifo_full = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {din, lo_half};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_half  <= '0;
      lo_valid <= 1'b0;
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
    end else begin
      if (wr_lo) begin
        lo_half  <= din;
        lo_valid <= 1'b1;
      end else if (wr_hi) begin
        lo_valid <= 1'b0;
      end
      if (push)  wptr <= nxt(wptr);
      if (start) rptr <= nxt(rptr);
      case ({push, start})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sh    <= '0;
      bitn  <= '0;
      phase <= '0;
      gcnt  <= '0;
      pre   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_SEND;
            sh    <= {b32, head[WORD_W-2:0]};
            bitn  <= '0;
            phase <= '0;
            pre   <= '0;
          end
        end
        S_SEND: begin
          pre <= (pre == SW'(SLOW_PRE - 1)) ? '0 : pre + 1'b1;
          if (tick) phase <= bit_end ? '0 : phase + 1'b1;
          if (bit_end) begin
            sh   <= sh >> 1;
            bitn <= bitn + 1'b1;
            if (bitn == BW'(WORD_W - 1)) begin
              state <= S_GAP;
              gcnt  <= '0;
            end
          end
        end
        default: begin
          pre <= (pre == SW'(SLOW_PRE - 1)) ? '0 : pre + 1'b1;
          if (tick) begin
            if (gcnt == GW'(GAP_TICKS - 1)) state <= S_IDLE;
            else gcnt <= gcnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/arinc_tx_chk.sv
module arinc_tx_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_hi,
  input logic          tx_en,
  input logic          line_one,
  input logic          line_zero,
  input logic          tx_ready,
  input logic          fifo_full,
  input logic          lo_valid,
  input logic          sending,
  input logic          start,
  input logic [CW-1:0] count
);
  p_lines_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_one && line_zero));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_hi && !start) |=> fifo_full);

  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && lo_valid && !fifo_full) |=> !tx_ready);

  p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_one || line_zero) |-> !tx_ready);

  p_start_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> $past(tx_en));
endmodule

bind arinc_tx arinc_tx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .tx_en(tx_en),
  .line_one(line_one), .line_zero(line_zero), .tx_ready(tx_ready),
  .fifo_full(fifo_full), .lo_valid(lo_valid), .sending(sending),
  .start(start), .count(count)
);

// File: tb/arinc_tx_test.sv
module arinc_tx_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic [15:0] din = '0;
  logic wr_lo = 0, wr_hi = 0, rate_slow = 0, par_en = 1, par_even = 0, tx_en = 0;
  logic line_one, line_zero, tx_ready, fifo_full;

  arinc_tx uut (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rate_slow(rate_slow), .par_en(par_en), .par_even(par_even), .tx_en(tx_en),
    .line_one(line_one), .line_zero(line_zero), .tx_ready(tx_ready),
    .fifo_full(fifo_full)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, bad = 0;
  int cyc = 0, got_n = 0, nb = 0, run = 0, last_rise = 0, word_end = 0;
  int iv_min, iv_max, hi_min, hi_max, both_hi = 0;
  logic [31:0] acc;
  logic prev = 0, act;
  logic [31:0] got [0:63];
  int gapv [0:63];

  task automatic stats_reset();
    iv_min = 1 << 30; iv_max = 0; hi_min = 1 << 30; hi_max = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev = 0; nb = 0; run = 0;
    end else begin
      act = line_one | line_zero;
      if (line_one && line_zero) both_hi++;
      if (act && !prev) begin
        if (nb == 0) begin
          if (got_n < 64) gapv[got_n] = cyc - word_end;
        end else begin
          if (cyc - last_rise < iv_min) iv_min = cyc - last_rise;
          if (cyc - last_rise > iv_max) iv_max = cyc - last_rise;
        end
        acc[nb] = line_one;
        nb++;
        last_rise = cyc;
        if (nb == 32) begin
          if (got_n < 64) got[got_n] = acc;
          got_n++;
          nb = 0;
          word_end = cyc;
        end
      end
      if (act) run++;
      else if (prev) begin
        if (run < hi_min) hi_min = run;
        if (run > hi_max) hi_max = run;
        run = 0;
      end
      prev = act;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] actual, input logic [31:0] expect_v);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expect_v);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] w, input logic pe, input logic ev);
    logic p;
    if (!pe) return w;
    p = ($countones(w[30:0]) % 2 == 0) ? ~ev : ev;
    return {p, w[30:0]};
  endfunction

  task automatic wr_word(input logic [31:0] w);
    @(negedge clk); din = w[15:0]; wr_lo = 1;
    @(negedge clk); wr_lo = 0; din = w[31:16]; wr_hi = 1;
    @(negedge clk); wr_hi = 0;
  endtask

  task automatic wait_words(input int n, input int maxc);
    for (int i = 0; i < maxc && got_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(input int maxc);
    for (int i = 0; i < maxc && !tx_ready; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tx_ready == 1, "R4", "ready after reset", 32'(tx_ready), 1);
    chk(fifo_full == 0, "R3", "full after reset", 32'(fifo_full), 0);
    chk((line_one | line_zero) == 0, "R9", "lines after reset", 32'(line_one | line_zero), 0);
  endtask

  task automatic t_hold_then_send();
    int base = got_n;
    logic [31:0] w = 32'h1234_5678;
    par_en = 1; par_even = 0; rate_slow = 0; tx_en = 0;
    wr_word(w);
    chk(tx_ready == 0, "R4", "ready after queue", 32'(tx_ready), 0);
    repeat (300) @(negedge clk);
    chk(got_n == base, "R11", "no start with tx_en low", 32'(got_n), 32'(base));
    stats_reset();
    tx_en = 1;
    wait_words(base + 1, 1000);
    chk(got[base] == exp_word(w, 1, 0), "R7", "bit order and content", got[base], exp_word(w, 1, 0));
    chk($countones(got[base]) % 2 == 1, "R6", "odd parity", got[base], 0);
    chk(tx_ready == 0, "R4", "ready during bit 32", 32'(tx_ready), 0);
    wait_ready(40);
    chk(tx_ready == 1, "R4", "ready after last bit", 32'(tx_ready), 1);
    chk(iv_min == 10 && iv_max == 10, "R8", "fast bit period", 32'(iv_max), 10);
    chk(hi_min == 5 && hi_max == 5, "R8", "fast pulse width", 32'(hi_max), 5);
  endtask

  task automatic t_half_strobes();
    int base = got_n;
    tx_en = 1; par_en = 1; par_even = 0;
    @(negedge clk); din = 16'hBEEF; wr_hi = 1;
    @(negedge clk); wr_hi = 0;
    repeat (200) @(negedge clk);
    chk(got_n == base, "R2", "lone high strobe ignored", 32'(got_n), 32'(base));
    chk(tx_ready == 1, "R2", "queue still empty", 32'(tx_ready), 1);
    @(negedge clk); din = 16'h00F0; wr_lo = 1;
    @(negedge clk); wr_lo = 0;
    repeat (200) @(negedge clk);
    chk(got_n == base, "R2", "low half alone not queued", 32'(got_n), 32'(base));
    @(negedge clk); din = 16'h0A0A; wr_hi = 1;
    @(negedge clk); wr_hi = 0;
    wait_words(base + 1, 1000);
    chk(got[base] == exp_word(32'h0A0A_00F0, 1, 0), "R2", "late high completes word",
        got[base], exp_word(32'h0A0A_00F0, 1, 0));
    wait_ready(100);
  endtask

  task automatic t_data_bit();
    int base = got_n;
    tx_en = 0; par_en = 0;
    wr_word(32'h8000_0001);
    wr_word(32'h0000_0003);
    tx_en = 1;
    wait_words(base + 2, 2000);
    chk(got[base] == 32'h8000_0001, "R5", "host bit 32 set", got[base], 32'h8000_0001);
    chk(got[base+1] == 32'h0000_0003, "R5", "host bit 32 clear", got[base+1], 32'h0000_0003);
    wait_ready(100);
  endtask

  task automatic t_even();
    int base = got_n;
    tx_en = 0; par_en = 1; par_even = 1;
    wr_word(32'h0000_0007);
    wr_word(32'hFFFF_0000);
    tx_en = 1;
    wait_words(base + 2, 2000);
    chk(got[base] == exp_word(32'h0000_0007, 1, 1), "R6", "even parity word A",
        got[base], exp_word(32'h0000_0007, 1, 1));
    chk(got[base+1] == exp_word(32'hFFFF_0000, 1, 1), "R6", "even parity word B",
        got[base+1], exp_word(32'hFFFF_0000, 1, 1));
    chk($countones(got[base+1]) % 2 == 0, "R6", "even ones count", got[base+1], 0);
    wait_ready(100);
  endtask

  task automatic t_full();
    int base = got_n;
    tx_en = 0; par_en = 0;
    for (int i = 0; i < 9; i++) begin
      wr_word(32'hA5A5_0000 | 32'(i * 17));
      if (i == 6) chk(fifo_full == 0, "R3", "not full at 7", 32'(fifo_full), 0);
      if (i == 7) chk(fifo_full == 1, "R3", "full at 8", 32'(fifo_full), 1);
    end
    chk(fifo_full == 1, "R3", "still full after extra write", 32'(fifo_full), 1);
    tx_en = 1;
    wait_words(base + 8, 8000);
    repeat (600) @(negedge clk);
    chk(got_n == base + 8, "R3", "ninth word dropped", 32'(got_n), 32'(base + 8));
    for (int i = 0; i < 8; i++)
      chk(got[base+i] == (32'hA5A5_0000 | 32'(i * 17)), "R1", "queue order",
          got[base+i], 32'hA5A5_0000 | 32'(i * 17));
    for (int i = 1; i < 8; i++)
      chk(gapv[base+i] >= 50, "R10", "inter-word gap", 32'(gapv[base+i]), 50);
    chk(tx_ready == 1, "R4", "ready after drain", 32'(tx_ready), 1);
  endtask

  task automatic t_slow();
    int base = got_n;
    logic [31:0] w = 32'h5A3C_C3A5;
    tx_en = 1; par_en = 1; par_even = 0; rate_slow = 1;
    stats_reset();
    wr_word(w);
    wait_words(base + 1, 4000);
    wait_ready(200);
    chk(got[base] == exp_word(w, 1, 0), "R7", "slow word content", got[base], exp_word(w, 1, 0));
    chk(iv_min == 80 && iv_max == 80, "R8", "slow bit period", 32'(iv_max), 80);
    chk(hi_min == 40 && hi_max == 40, "R8", "slow pulse width", 32'(hi_max), 40);
    rate_slow = 0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    stats_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hold_then_send();
    t_half_strobes();
    t_data_bit();
    t_even();
    t_full();
    t_slow();
    chk(both_hi == 0, "R9", "lines never high together", 32'(both_hi), 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule